// File: doc/BRIEF.md
# Manual DRAM Command Injection Register Bank

This block is a small bus-slave register file placed in front of a DDR3 PHY command interface. During memory bring-up, software uses it to step the DRAM through its power-up sequence by hand. Software can set the reset, clock-enable and termination pins directly. It can load a command pattern, a row/column address and a bank number into registers. It then fires the command onto the PHY bus for a single clock by writing a one-shot trigger register.

A mode bit in the control register picks the source of the command bus. In manual mode, the block drives every PHY-side pin from its own registers. In hardware mode, every pin comes straight from a pass-through port that the normal memory controller feeds. The slave port uses classic single-cycle Wishbone-style handshaking and is addressed in 32-bit words.

Top module: `dfi_inject_regs`

## Requirements
- R1: When reset is released, the block is in manual mode with the control register reading 0x1. The DRAM reset, CKE and ODT pins are low, the four command pins are high, and ack is low.
- R2: The word addresses are: 0 control (4 bits), 1 command (4 bits), 2 trigger, 3 address (ADDR_W bits), 4 bank (BANK_W bits). A read returns the stored value zero-extended. The trigger reads as 0. Addresses 5 to 7 read as 0, and writes to them change nothing.
- R3: A request (cyc and stb high) is acknowledged with ack high for exactly one cycle, the cycle after it is first presented. The master holds the request until it sees ack.
- R4: Control bit 1 drives CKE, bit 2 drives ODT and bit 3 drives the active-low DRAM reset pin. In manual mode these take the written value in the same cycle that ack is high.
- R5: Command bit 0 is chip select, bit 1 write enable, bit 2 column strobe and bit 3 row strobe. The bits are active-high in the register and appear inverted (active-low) on the outputs during an issue cycle. For example, 0xF is a mode-register set and 0x3 is a calibration command.
- R6: In manual mode, writing the trigger register with bit 0 set drives the stored command for exactly one clock, the cycle in which ack is high. The bus then returns to NOP. Writing bit 0 clear issues nothing.
- R7: In manual mode, the address and bank outputs show the address and bank registers.
- R8: With control bit 0 clear (hardware mode), every PHY-side output equals the matching pass-through input in the same cycle. Trigger writes issue nothing, and no command is left pending when manual mode returns.
- R9: In manual mode, outside an issue cycle, chip select, row strobe, column strobe and write enable outputs are all high (NOP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | WB_ADR_W | Word address |
| wb_dat_w | input | DATA_W | Write data |
| wb_dat_r | output | DATA_W | Read data, valid with ack |
| wb_ack | output | 1 | One-cycle acknowledge |
| hw_cs_n | input | 1 | Controller chip select, active low |
| hw_ras_n | input | 1 | Controller row strobe, active low |
| hw_cas_n | input | 1 | Controller column strobe, active low |
| hw_we_n | input | 1 | Controller write enable, active low |
| hw_addr | input | ADDR_W | Controller address |
| hw_bank | input | BANK_W | Controller bank |
| hw_cke | input | 1 | Controller clock enable |
| hw_odt | input | 1 | Controller termination enable |
| hw_reset_n | input | 1 | Controller DRAM reset, active low |
| dfi_cs_n | output | 1 | PHY chip select, active low |
| dfi_ras_n | output | 1 | PHY row strobe, active low |
| dfi_cas_n | output | 1 | PHY column strobe, active low |
| dfi_we_n | output | 1 | PHY write enable, active low |
| dfi_addr | output | ADDR_W | PHY address |
| dfi_bank | output | BANK_W | PHY bank |
| dfi_cke | output | 1 | PHY clock enable |
| dfi_odt | output | 1 | PHY termination enable |
| dfi_reset_n | output | 1 | PHY DRAM reset, active low |

## Verification
Register updates and the command pulse are due one clock edge after a request is sampled, so they are visible in the cycle where ack is high. The return to NOP and the drop of ack come one edge later. In hardware mode, the outputs follow the inputs with no clock. The bench therefore samples one time unit after the edge that raises ack for write effects, pulses and read data, and one unit after the next edge for ack low and NOP. It checks pass-through combinationally, one unit after changing the inputs. Sweeps cover all 16 command codes, all 8 pin combinations of the control register and 16 pass-through patterns, with expected values derived from the bit positions in the requirements.

// File: rtl/dfi_inject_pkg.sv
`timescale 1ns/1ps
// Package: shared field layouts and word offsets of the command injection bank.
// Assumes the bus is word addressed; offsets below are word indices.
package dfi_inject_pkg;

    localparam int unsigned CTRL_W   = 4;
    localparam int unsigned CMD_W    = 4;

    localparam int unsigned OFF_CTRL = 0;
    localparam int unsigned OFF_CMD  = 1;
    localparam int unsigned OFF_TRIG = 2;
    localparam int unsigned OFF_ADDR = 3;
    localparam int unsigned OFF_BANK = 4;

    // Control register layout, bit 3 down to bit 0.
    typedef struct packed {
        logic rst_rel;   // bit 3: DRAM reset released (pin high)
        logic odt;       // bit 2: termination enable
        logic cke;       // bit 1: clock enable
        logic manual;    // bit 0: register bank owns the bus
    } ctrl_t;

    // Command register layout, bit 3 down to bit 0, active-high.
    typedef struct packed {
        logic ras;       // bit 3
        logic cas;       // bit 2
        logic we;        // bit 1
        logic cs;        // bit 0
    } cmd_t;

    localparam ctrl_t CTRL_RESET = '{rst_rel: 1'b0, odt: 1'b0, cke: 1'b0, manual: 1'b1};

endpackage

// File: rtl/dfi_inject_csr.sv
`timescale 1ns/1ps
// Module: dfi_inject_csr
// Bus-slave register file. Decodes word-addressed single-beat requests,
// stores control, command, address and bank registers, returns read data
// and a one-cycle acknowledge the cycle after a request is seen.
// Assumes the master holds cyc/stb until ack. Flags an accepted trigger
// write with bit 0 set for one cycle (same edge that raises ack).
module dfi_inject_csr
    import dfi_inject_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WB_ADR_W = 3,
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned BANK_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wb_cyc,
    input  logic                wb_stb,
    input  logic                wb_we,
    input  logic [WB_ADR_W-1:0] wb_adr,
    input  logic [DATA_W-1:0]   wb_dat_w,
    output logic [DATA_W-1:0]   wb_dat_r,
    output logic                wb_ack,
    output ctrl_t               ctrl_q,
    output cmd_t                cmd_q,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [BANK_W-1:0]   bank_q,
    output logic                trig_fire
);

    localparam logic [WB_ADR_W-1:0] A_CTRL = WB_ADR_W'(OFF_CTRL);
    localparam logic [WB_ADR_W-1:0] A_CMD  = WB_ADR_W'(OFF_CMD);
    localparam logic [WB_ADR_W-1:0] A_TRIG = WB_ADR_W'(OFF_TRIG);
    localparam logic [WB_ADR_W-1:0] A_ADDR = WB_ADR_W'(OFF_ADDR);
    localparam logic [WB_ADR_W-1:0] A_BANK = WB_ADR_W'(OFF_BANK);

    logic                accept;
    logic                wr_en;
    logic                rd_en;
    logic [DATA_W-1:0]   rd_mux;
    logic                unused_wdat;

    // New request: valid cycle not already being acknowledged.
    assign accept = wb_cyc && wb_stb && !wb_ack;
    assign wr_en  = accept && wb_we;
    assign rd_en  = accept && !wb_we;
    assign unused_wdat = ^wb_dat_w[DATA_W-1:ADDR_W];

    // Acknowledge each accepted request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_ack <= 1'b0;
        else        wb_ack <= accept;
    end

    // Store register writes; unmapped and trigger addresses hold nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            cmd_q  <= '0;
            addr_q <= '0;
            bank_q <= '0;
        end else if (wr_en) begin
            case (wb_adr)
                A_CTRL:  ctrl_q <= ctrl_t'(wb_dat_w[CTRL_W-1:0]);
                A_CMD:   cmd_q  <= cmd_t'(wb_dat_w[CMD_W-1:0]);
                A_ADDR:  addr_q <= wb_dat_w[ADDR_W-1:0];
                A_BANK:  bank_q <= wb_dat_w[BANK_W-1:0];
                default: ;
            endcase
        end
    end

    // Select the read value; trigger and unmapped words read as zero.
    always_comb begin
        case (wb_adr)
            A_CTRL:  rd_mux = DATA_W'(ctrl_q);
            A_CMD:   rd_mux = DATA_W'(cmd_q);
            A_ADDR:  rd_mux = DATA_W'(addr_q);
            A_BANK:  rd_mux = DATA_W'(bank_q);
            default: rd_mux = '0;
        endcase
    end

    // Register read data alongside the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     wb_dat_r <= '0;
        else if (rd_en) wb_dat_r <= rd_mux;
    end

    // Trigger request: write to the trigger word with bit 0 set.
    assign trig_fire = wr_en && (wb_adr == A_TRIG) && wb_dat_w[0];

endmodule

// File: rtl/dfi_inject_pulse.sv
`timescale 1ns/1ps
// Module: dfi_inject_pulse
// Turns a trigger request into a single-cycle issue window and produces
// the active-low command pins for the manual path. Outside the window the
// pins read NOP (all high). Assumes trig_fire is a one-cycle flag.
module dfi_inject_pulse
    import dfi_inject_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fire,
    input  logic             manual,
    input  cmd_t             cmd_q,
    output logic             issue_q,
    output logic [CMD_W-1:0] cmd_n
);

    logic [CMD_W-1:0] cmd_bits;

    // Open the issue window for one clock, only in manual mode.
    always_ff @(posedge clk) begin
        if (!rst_n) issue_q <= 1'b0;
        else        issue_q <= trig_fire && manual;
    end

    assign cmd_bits = cmd_q;

    // Each pin is low only while issuing and its register bit is set.
    for (genvar i = 0; i < CMD_W; i++) begin : g_pin
        assign cmd_n[i] = ~(issue_q & cmd_bits[i]);
    end

endmodule

// File: rtl/dfi_inject_mux.sv
`timescale 1ns/1ps
// Module: dfi_inject_mux
// Chooses between the manual register path and the controller pass-through
// for every PHY-side pin. Purely combinational; assumes both buses share
// the same flat layout built by the caller.
module dfi_inject_mux #(
    parameter int unsigned BUS_W = 24
) (
    input  logic             sel_manual,
    input  logic [BUS_W-1:0] man_bus,
    input  logic [BUS_W-1:0] hw_bus,
    output logic [BUS_W-1:0] out_bus
);

    // Bitwise selection of the bus owner.
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        assign out_bus[i] = sel_manual ? man_bus[i] : hw_bus[i];
    end

endmodule

// File: rtl/dfi_inject_regs.sv
`timescale 1ns/1ps
// Module: dfi_inject_regs (top)
// Software command injection bank for a DRAM PHY command bus. A word-
// addressed slave port loads control, command, address and bank registers;
// a trigger write fires the command for one clock. Control bit 0 hands the
// bus to the controller pass-through port. Synchronous active-low reset.
module dfi_inject_regs
    import dfi_inject_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WB_ADR_W = 3,
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned BANK_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wb_cyc,
    input  logic                wb_stb,
    input  logic                wb_we,
    input  logic [WB_ADR_W-1:0] wb_adr,
    input  logic [DATA_W-1:0]   wb_dat_w,
    output logic [DATA_W-1:0]   wb_dat_r,
    output logic                wb_ack,
    input  logic                hw_cs_n,
    input  logic                hw_ras_n,
    input  logic                hw_cas_n,
    input  logic                hw_we_n,
    input  logic [ADDR_W-1:0]   hw_addr,
    input  logic [BANK_W-1:0]   hw_bank,
    input  logic                hw_cke,
    input  logic                hw_odt,
    input  logic                hw_reset_n,
    output logic                dfi_cs_n,
    output logic                dfi_ras_n,
    output logic                dfi_cas_n,
    output logic                dfi_we_n,
    output logic [ADDR_W-1:0]   dfi_addr,
    output logic [BANK_W-1:0]   dfi_bank,
    output logic                dfi_cke,
    output logic                dfi_odt,
    output logic                dfi_reset_n
);

    localparam int unsigned BUS_W = CMD_W + ADDR_W + BANK_W + 3;

    ctrl_t              ctrl_q;
    cmd_t               cmd_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [BANK_W-1:0]  bank_q;
    logic               trig_fire;
    logic               issue_q;
    logic               manual;
    logic [CMD_W-1:0]   cmd_n;
    logic [BUS_W-1:0]   man_bus;
    logic [BUS_W-1:0]   hw_bus;
    logic [BUS_W-1:0]   out_bus;

    dfi_inject_csr #(
        .DATA_W   (DATA_W),
        .WB_ADR_W (WB_ADR_W),
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_we     (wb_we),
        .wb_adr    (wb_adr),
        .wb_dat_w  (wb_dat_w),
        .wb_dat_r  (wb_dat_r),
        .wb_ack    (wb_ack),
        .ctrl_q    (ctrl_q),
        .cmd_q     (cmd_q),
        .addr_q    (addr_q),
        .bank_q    (bank_q),
        .trig_fire (trig_fire)
    );

    assign manual = ctrl_q.manual;

    dfi_inject_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_fire (trig_fire),
        .manual    (manual),
        .cmd_q     (cmd_q),
        .issue_q   (issue_q),
        .cmd_n     (cmd_n)
    );

    // Flat bus layout: {ras_n, cas_n, we_n, cs_n, addr, bank, cke, odt, reset_n}.
    assign man_bus = {cmd_n, addr_q, bank_q, ctrl_q.cke, ctrl_q.odt, ctrl_q.rst_rel};
    assign hw_bus  = {hw_ras_n, hw_cas_n, hw_we_n, hw_cs_n, hw_addr, hw_bank,
                      hw_cke, hw_odt, hw_reset_n};

    dfi_inject_mux #(
        .BUS_W (BUS_W)
    ) u_mux (
        .sel_manual (manual),
        .man_bus    (man_bus),
        .hw_bus     (hw_bus),
        .out_bus    (out_bus)
    );

    assign {dfi_ras_n, dfi_cas_n, dfi_we_n, dfi_cs_n, dfi_addr, dfi_bank,
            dfi_cke, dfi_odt, dfi_reset_n} = out_bus;

endmodule

// File: rtl/dfi_inject_chk.sv
`timescale 1ns/1ps
// Module: dfi_inject_chk
// Property checker for dfi_inject_regs, attached by bind. Observes the
// slave port, the PHY-side pins and the internal mode and issue signals.
module dfi_inject_chk
    import dfi_inject_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WB_ADR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wb_cyc,
    input logic                wb_stb,
    input logic                wb_we,
    input logic [WB_ADR_W-1:0] wb_adr,
    input logic [DATA_W-1:0]   wb_dat_w,
    input logic                wb_ack,
    input logic                manual,
    input logic                issue_q,
    input logic                dfi_cs_n,
    input logic                dfi_ras_n,
    input logic                dfi_cas_n,
    input logic                dfi_we_n,
    input logic                dfi_cke,
    input logic                dfi_odt,
    input logic                dfi_reset_n
);

    logic req_new;
    assign req_new = wb_cyc && wb_stb && !wb_ack;

    p_rst_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!dfi_cke && !dfi_odt && !dfi_reset_n && dfi_cs_n && !wb_ack));

    p_ack_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_new |=> wb_ack);

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    p_ctrl_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_new && wb_we && wb_adr == WB_ADR_W'(OFF_CTRL) && wb_dat_w[0])
        |=> (dfi_cke == $past(wb_dat_w[1]) && dfi_odt == $past(wb_dat_w[2])
             && dfi_reset_n == $past(wb_dat_w[3])));

    p_cmd_after_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && !dfi_cs_n) |-> $past(req_new && wb_we
            && wb_adr == WB_ADR_W'(OFF_TRIG) && wb_dat_w[0]));

    p_cmd_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && !dfi_cs_n) |=> (dfi_cs_n || !manual));

    p_nop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && !issue_q) |-> (dfi_cs_n && dfi_ras_n && dfi_cas_n && dfi_we_n));

endmodule

bind dfi_inject_regs dfi_inject_chk #(
    .DATA_W   (DATA_W),
    .WB_ADR_W (WB_ADR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_cyc      (wb_cyc),
    .wb_stb      (wb_stb),
    .wb_we       (wb_we),
    .wb_adr      (wb_adr),
    .wb_dat_w    (wb_dat_w),
    .wb_ack      (wb_ack),
    .manual      (manual),
    .issue_q     (issue_q),
    .dfi_cs_n    (dfi_cs_n),
    .dfi_ras_n   (dfi_ras_n),
    .dfi_cas_n   (dfi_cas_n),
    .dfi_we_n    (dfi_we_n),
    .dfi_cke     (dfi_cke),
    .dfi_odt     (dfi_odt),
    .dfi_reset_n (dfi_reset_n)
);

// File: tb/dfi_inject_regs_tb.sv
`timescale 1ns/1ps
// Bench: sweeps control, command and pass-through patterns on dfi_inject_regs.
module dfi_inject_regs_tb;

    localparam int DATA_W = 32, WB_ADR_W = 3, ADDR_W = 14, BANK_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [WB_ADR_W-1:0] wb_adr = '0;
    logic [DATA_W-1:0]   wb_dat_w = '0;
    logic [DATA_W-1:0]   wb_dat_r;
    logic                wb_ack;
    logic hw_cs_n = 1, hw_ras_n = 1, hw_cas_n = 1, hw_we_n = 1;
    logic [ADDR_W-1:0] hw_addr = '0;
    logic [BANK_W-1:0] hw_bank = '0;
    logic hw_cke = 0, hw_odt = 0, hw_reset_n = 0;
    logic dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n, dfi_cke, dfi_odt, dfi_reset_n;
    logic [ADDR_W-1:0] dfi_addr;
    logic [BANK_W-1:0] dfi_bank;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [6:0] snap, post;   // {cs_n, ras_n, cas_n, we_n, cke, odt, reset_n}
    logic [DATA_W-1:0] rd;

    always #5 clk = ~clk;

    dfi_inject_regs #(.DATA_W(DATA_W), .WB_ADR_W(WB_ADR_W), .ADDR_W(ADDR_W),
                      .BANK_W(BANK_W)) u_dut (.*);

    function automatic logic [6:0] pins();
        return {dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n, dfi_cke, dfi_odt, dfi_reset_n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus access: snap taken while ack is high, post one cycle later.
    task automatic access(input bit we, input int adr, input logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = WB_ADR_W'(adr); wb_dat_w = d;
        @(posedge clk); #1;
        check(wb_ack === 1'b1, "R3 ack high", 32'(wb_ack), 1);
        snap = pins(); rd = wb_dat_r;
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
        @(posedge clk); #1;
        check(wb_ack === 1'b0, "R3 ack single", 32'(wb_ack), 0);
        post = pins();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        // R1: reset state
        check(pins() === 7'b1111000, "R1 pins", 32'(pins()), 32'h78);
        check(wb_ack === 1'b0, "R1 ack", 32'(wb_ack), 0);
        access(0, 0, 0);
        check(rd === 32'h1, "R1 R2 ctrl reset read", rd, 1);

        // R4 R2 R9: sweep pin bits of control in manual mode
        for (int v = 0; v < 8; v++) begin
            access(1, 0, 32'((v << 1) | 1));
            check(snap[2:0] === {v[0], v[1], v[2]}, "R4 pins follow control",
                  32'(snap[2:0]), 32'({v[0], v[1], v[2]}));
            check(snap[6:3] === 4'hF, "R9 nop", 32'(snap[6:3]), 32'hF);
            access(0, 0, 0);
            check(rd === 32'((v << 1) | 1), "R2 ctrl read", rd, 32'((v << 1) | 1));
        end

        // R7 R2: address and bank registers
        access(1, 3, 32'hFFFF_2A5A);
        check(dfi_addr === 14'h2A5A, "R7 addr out", 32'(dfi_addr), 32'h2A5A);
        access(0, 3, 0);
        check(rd === 32'h2A5A, "R2 addr read masked", rd, 32'h2A5A);
        access(1, 4, 32'hFFFF_FFFD);
        check(dfi_bank === 3'd5, "R7 bank out", 32'(dfi_bank), 5);
        access(0, 4, 0);
        check(rd === 32'h5, "R2 bank read masked", rd, 5);

        // R5 R6 R9: every command code through the trigger
        for (int c = 0; c < 16; c++) begin
            access(1, 1, 32'(c));
            check(snap[6:3] === 4'hF, "R9 nop after cmd load", 32'(snap[6:3]), 32'hF);
            access(0, 1, 0);
            check(rd === 32'(c), "R2 cmd read", rd, 32'(c));
            access(1, 2, 32'h1);
            // pins {cs_n, ras_n, cas_n, we_n} = ~{c0, c3, c2, c1}
            check(snap[6:3] === ~{c[0], c[3], c[2], c[1]}, "R5 R6 cmd pulse",
                  32'(snap[6:3]), 32'(~{c[0], c[3], c[2], c[1]} & 4'hF));
            check(post[6:3] === 4'hF, "R6 back to nop", 32'(post[6:3]), 32'hF);
        end
        access(1, 2, 32'hFFFF_FFFE);
        check(snap[6:3] === 4'hF, "R6 bit0 clear no issue", 32'(snap[6:3]), 32'hF);
        access(0, 2, 0);
        check(rd === 32'h0, "R2 trigger reads zero", rd, 0);
        for (int a = 5; a < 8; a++) begin
            access(1, a, 32'hFFFF_FFF0);
            access(0, a, 0);
            check(rd === 32'h0, "R2 unmapped read", rd, 0);
        end
        access(0, 0, 0);
        check(rd === 32'hF, "R2 unmapped write ignored", rd, 32'hF);

        // R8: hardware pass-through
        access(1, 0, 32'h0);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            {hw_we_n, hw_cas_n, hw_ras_n, hw_cs_n} = 4'(k);
            hw_cke = k[1]; hw_odt = k[2]; hw_reset_n = k[3];
            hw_addr = 14'(k * 32'h111); hw_bank = 3'(k);
            #1;
            check(pins() === {k[0], k[1], k[2], k[3], k[1], k[2], k[3]}, "R8 pins pass",
                  32'(pins()), 32'({k[0], k[1], k[2], k[3], k[1], k[2], k[3]}));
            check({dfi_addr, dfi_bank} === {14'(k * 32'h111), 3'(k)}, "R8 addr bank pass",
                  32'({dfi_addr, dfi_bank}), 32'({14'(k * 32'h111), 3'(k)}));
        end
        @(negedge clk);
        {hw_we_n, hw_cas_n, hw_ras_n, hw_cs_n} = 4'hF;
        access(1, 1, 32'hF);
        access(1, 2, 32'h1);
        check(snap[6:3] === 4'hF, "R8 trigger ignored", 32'(snap[6:3]), 32'hF);
        access(1, 0, 32'h1);
        check(post[6:3] === 4'hF, "R8 nothing pending", 32'(post[6:3]), 32'hF);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule